// File: doc/BRIEF.md
# Phase build-out reference switcher

This block picks one of several input reference clocks and hides the phase step that a change of reference would otherwise put on the loop filter. Each reference has a programmable priority and an externally supplied health flag. The block stays on its current reference for as long as that reference is healthy. When it fails, the block moves to the best healthy candidate and reports a lost-phase mode. During that mode it learns the new reference's phase error and stores it as an offset. From then on it subtracts the offset from the phase error that it forwards.

A two-bit policy register decides how the offset behaves across switches. When enabled, each switch relearns the offset. When frozen, the offset already stored is kept. When disabled, the offset is forced to zero and the loop relocks to zero phase error. If no reference is healthy, the block enters holdover. In holdover it forwards a zero error and keeps its offset. The phase detector that produces the per-reference errors and the loop filter that consumes the result sit outside this block.

Top module: `pbo_ref_switch`

## Requirements
- R1: On a failover, the new selection is the reference with valid=1 and a nonzero priority whose priority value is the smallest. Ties go to the lower index, and priority value 0 disables an input. While the selected reference stays usable (valid=1 and nonzero priority), no switch happens, even if a better reference becomes usable.
- R2: `mode` reports 0 for locked, 1 for lost-phase and 2 for holdover. Lost-phase is entered on each switch and lasts `lost_len` phase-detector ticks (`pd_tick`); a length of 0 counts as 1. After that, mode returns to locked.
- R3: With the policy enabled (code 01), the first tick in lost-phase stores the selected reference's phase error as the offset. From that tick on, `phase_out` equals the selected error minus the offset, so the step seen at the switch is zero. This is well inside the 120 ns bound.
- R4: With the policy frozen (code 10), a switch stores no new offset, and the previous offset keeps being subtracted.
- R5: With the policy disabled (code 00), the offset is zero from the next cycle on, and `phase_out` equals the raw selected error.
- R6: After reset, the policy reads 01 (enabled), mode is 2, `holdover` is 1, `sel_idx` is 0 and `phase_out` is 0. A write of code 11 has no effect.
- R7: `phase_out` saturates at -32768 and +32767 instead of wrapping.
- R8: With no usable reference, mode is 2, `holdover` is 1 and `phase_out` is 0. The offset is kept and applies again after recovery when the policy is frozen.
- R9: In lost-phase before the first tick, `phase_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_valid | input | NREF | Per-reference health flag |
| ref_prio | input | NREF*4 | Per-reference priority, 4 bits each, 0 = disabled |
| ref_phase | input | NREF*PW | Per-reference signed phase error |
| pd_tick | input | 1 | Phase-detector update strobe |
| lost_len | input | LW | Lost-phase length in ticks |
| ctl_we | input | 1 | Policy write strobe |
| ctl_wdata | input | 2 | Policy code: 00 disabled, 01 enabled, 10 frozen |
| phase_out | output | PW | Corrected signed phase error |
| sel_idx | output | $clog2(NREF) | Selected reference |
| mode | output | 2 | 0 locked, 1 lost-phase, 2 holdover |
| holdover | output | 1 | High in holdover |
| ctl_state | output | 2 | Current policy code |

## Verification
The assertions assume that the health flags and priorities are synchronous to `clk` and that any change between edges is seen as one new value. They also assume that a disabled or invalid reference is never treated as usable. The stimulus changes flags, priorities and phases only at the falling edge. Between failures it holds the configuration long enough for each lost-phase window to finish. The random phase errors stay within the 16-bit signed range.

// File: rtl/pbo_ref_switch.sv
module pbo_ref_switch #(
  parameter int NREF = 4,
  parameter int PW   = 16,
  parameter int LW   = 8,
  localparam int IW  = (NREF > 1) ? $clog2(NREF) : 1,
  localparam int PRW = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NREF-1:0]      ref_valid,
  input  logic [NREF*PRW-1:0]  ref_prio,
  input  logic [NREF*PW-1:0]   ref_phase,
  input  logic                 pd_tick,
  input  logic [LW-1:0]        lost_len,
  input  logic                 ctl_we,
  input  logic [1:0]           ctl_wdata,
  output logic signed [PW-1:0] phase_out,
  output logic [IW-1:0]        sel_idx,
  output logic [1:0]           mode,
  output logic                 holdover,
  output logic [1:0]           ctl_state
);
  localparam logic [1:0] M_LOCK = 2'd0, M_LOST = 2'd1, M_HOLD = 2'd2;
  localparam logic [1:0] C_DIS = 2'b00, C_EN = 2'b01, C_FRZ = 2'b10;
  localparam logic signed [PW:0] SMAX = (PW+1)'((1 << (PW-1)) - 1);
  localparam logic signed [PW:0] SMIN = -SMAX - 1;

  logic [1:0]           mode_q, ctl_q;
  logic [IW-1:0]        sel_q, best_idx;
  logic signed [PW-1:0] offset_q, sel_phase;
  logic [LW-1:0]        cnt_q, len_eff;
  logic                 cap_q, best_ok, cur_ok;
  logic [PRW-1:0]       best_pr;
  logic signed [PW:0]   diff;

  always_comb begin
    best_ok  = 1'b0;
    best_idx = '0;
    best_pr  = '1;
    for (int i = 0; i < NREF; i++) begin
      if (ref_valid[i] && ref_prio[i*PRW +: PRW] != '0 &&
          (!best_ok || ref_prio[i*PRW +: PRW] < best_pr)) begin
        best_ok  = 1'b1;
        best_idx = IW'(i);
        best_pr  = ref_prio[i*PRW +: PRW];
      end
    end
  end

  assign cur_ok    = ref_valid[sel_q] && (ref_prio[sel_q*PRW +: PRW] != '0);
  assign sel_phase = ref_phase[sel_q*PW +: PW];
  assign len_eff   = (lost_len == '0) ? LW'(1) : lost_len;
  assign diff      = (PW+1)'(sel_phase) - (PW+1)'(offset_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= M_HOLD;
      ctl_q    <= C_EN;
      sel_q    <= '0;
      offset_q <= '0;
      cnt_q    <= '0;
      cap_q    <= 1'b0;
    end else begin
      if (ctl_we && ctl_wdata != 2'b11) ctl_q <= ctl_wdata;
      if (ctl_q == C_DIS) offset_q <= '0;
      case (mode_q)
        M_LOCK, M_LOST: begin
          if (!cur_ok) begin
            if (best_ok) begin
              sel_q  <= best_idx;
              mode_q <= M_LOST;
              cnt_q  <= '0;
              cap_q  <= 1'b0;
            end else begin
              mode_q <= M_HOLD;
            end
          end else if (mode_q == M_LOST && pd_tick) begin
            if (!cap_q) begin
              cap_q <= 1'b1;
              if (ctl_q == C_EN) offset_q <= sel_phase;
            end
            if (cnt_q + LW'(1) >= len_eff) mode_q <= M_LOCK;
            else cnt_q <= cnt_q + LW'(1);
          end
        end
        default: begin
          if (best_ok) begin
            sel_q  <= best_idx;
            mode_q <= M_LOST;
            cnt_q  <= '0;
            cap_q  <= 1'b0;
          end
        end
      endcase
    end
  end

  assign phase_out = !(mode_q == M_LOCK || (mode_q == M_LOST && cap_q)) ? '0 :
                     (diff > SMAX) ? PW'(SMAX) :
                     (diff < SMIN) ? PW'(SMIN) : PW'(diff);
  assign sel_idx   = sel_q;
  assign mode      = mode_q;
  assign holdover  = (mode_q == M_HOLD);
  assign ctl_state = ctl_q;

  assert_leave_lock_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == M_LOCK && mode_q != M_LOCK) |-> !$past(cur_ok));
  assert_sel_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_LOCK && $past(mode_q) == M_LOCK) |-> $stable(sel_q));
  assert_hold_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_HOLD && best_ok) |=> (mode_q == M_LOST));
  assert_frozen_keep_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == C_FRZ) |=> $stable(offset_q));
  assert_dis_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == C_DIS) |=> (offset_q == '0));
  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    holdover |-> (phase_out == '0 && mode == M_HOLD));
endmodule

// File: tb/tb_pbo_ref_switch.sv
`timescale 1ns/1ps
module tb_pbo_ref_switch;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic [N-1:0] valid = '0;
  logic [3:0] pr [N];
  logic signed [15:0] ph [N];
  logic [N*4-1:0] prio_f;
  logic [N*16-1:0] ph_f;
  logic tick = 0, we = 0;
  logic [7:0] llen = 8'd3;
  logic [1:0] wd = 2'b01;
  logic signed [15:0] pout;
  logic [1:0] sel, md, cst;
  logic hov;

  always_comb for (int i = 0; i < N; i++) begin
    prio_f[i*4 +: 4] = pr[i];
    ph_f[i*16 +: 16] = ph[i];
  end

  pbo_ref_switch dut (.clk(clk), .rst_n(rst_n), .ref_valid(valid), .ref_prio(prio_f),
    .ref_phase(ph_f), .pd_tick(tick), .lost_len(llen), .ctl_we(we), .ctl_wdata(wd),
    .phase_out(pout), .sel_idx(sel), .mode(md), .holdover(hov), .ctl_state(cst));

  int checks = 0, errors = 0;
  string tag = "R6";
  logic [1:0] m_mode = 2, m_ctl = 1, m_sel = 0;
  logic signed [15:0] m_off = 0;
  int m_cnt = 0;
  bit m_cap = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  function automatic int best(output bit ok);
    int b = 0; int bp = 99; ok = 0;
    for (int i = 0; i < N; i++)
      if (valid[i] && pr[i] != 0 && int'(pr[i]) < bp) begin bp = pr[i]; b = i; ok = 1; end
    return b;
  endfunction

  function automatic int exp_out();
    int d;
    if (!(m_mode == 0 || (m_mode == 1 && m_cap))) return 0;
    d = int'(ph[m_sel]) - int'(m_off);
    if (d > 32767) d = 32767;
    if (d < -32768) d = -32768;
    return d;
  endfunction

  task automatic model_step();
    bit bok; int b; bit cok; logic [1:0] oc;
    b = best(bok);
    cok = valid[m_sel] && pr[m_sel] != 0;
    oc = m_ctl;
    if (we && wd != 2'b11) m_ctl = wd;
    if (oc == 2'b00) m_off = 0;
    if (m_mode != 2) begin
      if (!cok) begin
        if (bok) begin m_sel = 2'(b); m_mode = 1; m_cnt = 0; m_cap = 0; end
        else m_mode = 2;
      end else if (m_mode == 1 && tick) begin
        if (!m_cap) begin m_cap = 1; if (oc == 2'b01) m_off = ph[m_sel]; end
        if (m_cnt + 1 >= ((llen == 0) ? 1 : int'(llen))) m_mode = 0; else m_cnt++;
      end
    end else if (bok) begin
      m_sel = 2'(b); m_mode = 1; m_cnt = 0; m_cap = 0;
    end
  endtask

  task automatic cyc();
    #1;
    chk(md == m_mode, {tag, "/R2 mode"}, md, m_mode);
    chk(sel == m_sel, {tag, "/R1 sel"}, sel, m_sel);
    chk(hov == (m_mode == 2), {tag, "/R8 holdover"}, hov, m_mode == 2);
    chk(cst == m_ctl, {tag, "/R6 ctl"}, cst, m_ctl);
    chk(int'(pout) == exp_out(), {tag, "/R3 phase"}, pout, exp_out());
    @(posedge clk);
    model_step();
    @(negedge clk);
    we = 0;
  endtask

  task automatic run(input int n, input bit tk);
    for (int k = 0; k < n; k++) begin tick = tk; cyc(); end
    tick = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin pr[i] = 4'(i + 1); ph[i] = 16'(100 * (i + 1)); end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    tag = "R6"; run(1, 0);
    chk(pout == 0 && md == 2, "R6 reset", pout, 0);
    tag = "R6"; we = 1; wd = 2'b11; run(1, 0);
    chk(cst == 2'b01, "R6 code11 ignored", cst, 1);

    tag = "R9"; valid = '1; run(3, 0);
    tag = "R2"; run(4, 1);
    chk(md == 0 && sel == 0 && pout == 0, "R3 first lock step zero", pout, 0);
    ph[0] = 150; run(2, 0);

    tag = "R1"; valid[0] = 0; pr[3] = 1; run(2, 0); run(4, 1);
    chk(sel == 3, "R1 tie to priority winner", sel, 3);
    pr[0] = 1; valid[0] = 1; run(3, 0);
    chk(sel == 3, "R1 non-revertive", sel, 3);

    tag = "R4"; we = 1; wd = 2'b10; run(1, 0);
    ph[1] = 5000; valid[3] = 0; pr[0] = 0; run(2, 0); run(4, 1);
    chk(int'(pout) == 5000 - 400, "R4 frozen offset kept", pout, 4600);

    tag = "R8"; valid = '0; run(3, 1);
    chk(hov && pout == 0, "R8 holdover", pout, 0);
    valid[2] = 1; ph[2] = 1000; run(2, 0); run(4, 1);
    chk(int'(pout) == 600, "R8 offset survives", pout, 600);

    tag = "R5"; we = 1; wd = 2'b00; run(2, 0);
    chk(int'(pout) == 1000, "R5 disabled raw", pout, 1000);

    tag = "R7"; we = 1; wd = 2'b01; run(1, 0);
    valid = 4'b0010; ph[1] = 30000; run(1, 0); run(4, 1);
    ph[1] = -30000; run(2, 0);
    chk(int'(pout) == -32768, "R7 negative clamp", pout, -32768);
    ph[1] = 30000; valid = 4'b1010; pr[3] = 2; ph[3] = -30000; valid[1] = 0;
    run(1, 0); run(4, 1); ph[3] = 30000; run(2, 0);
    chk(int'(pout) == 32767, "R7 positive clamp", pout, 32767);

    tag = "R2"; llen = 0; valid = 4'b0101; pr[0] = 1; pr[2] = 3; run(2, 0); run(2, 1);

    tag = "R1";
    for (int k = 0; k < 3000; k++) begin
      for (int i = 0; i < N; i++) ph[i] = 16'($urandom_range(0, 65535));
      if ($urandom_range(0, 15) == 0) begin
        valid = 4'($urandom);
        for (int i = 0; i < N; i++) pr[i] = 4'($urandom_range(0, 15));
      end
      if ($urandom_range(0, 63) == 0) begin we = 1; wd = 2'($urandom); end
      llen = 8'($urandom_range(0, 5));
      tick = $urandom_range(0, 1);
      cyc();
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule